// File: doc/BRIEF.md
# Latched Threshold Alarm Flags

This block watches a set of 16-bit monitor readings (two module-wide quantities, temperature and supply voltage, plus received power, transmit bias and transmit power for each of four channels) and checks each reading against four limits: an upper and a lower alarm, and an upper and a lower warning. Any limit crossing is stored in a sticky flag bit. Per-channel loss-of-signal and transmit-fault inputs are captured the same way. The flags are packed four to a nibble in byte-wide flag registers at fixed addresses, because host software decodes those addresses.

A host reaches the block through a simple byte read/write port that sits behind the serial bus. Reading a flag byte returns its contents and clears every flag in that byte. A mask register shadows each flag byte. Masked flags still latch but do not pull the active-low interrupt output. A status byte shows the current interrupt pin level and a not-ready bit. The not-ready bit stays set until the first valid monitor sample arrives.

Top module: `alarm_flag_bank`

## Requirements
- R1: After reset all flag bytes and mask bytes read 0x00, `irq_n_o` is 1 and the status byte at address 2 reads 0x03.
- R2: On a sample strobe, a reading strictly above its upper alarm limit sets bit 3 of its nibble and a reading strictly above its upper warning limit sets bit 1 of its nibble. The nibble is bits 7..4 or bits 3..0 of the flag byte. A reading equal to a limit sets nothing.
- R3: On a sample strobe, a reading strictly below its lower alarm limit sets nibble bit 2 and a reading strictly below its lower warning limit sets nibble bit 0. Equality sets nothing.
- R4: Limits are compared only in cycles where `mon_valid_i` is 1. Flag byte addresses are fixed: temperature in byte 6 high nibble, supply in byte 7 high nibble, received power in bytes 9–10, transmit bias in bytes 11–12 and transmit power in bytes 13–14. Within each pair of bytes, channel 1 is the high nibble of the first byte, channel 2 its low nibble, channel 3 the high nibble of the second byte and channel 4 its low nibble.
- R5: Channel n loss-of-signal (`los_i[n-1]`) sets bit n-1 of byte 3, and channel n transmit fault sets bit n-1 of byte 4, in any cycle where the input is 1. Bits 7..4 of both bytes stay 0.
- R6: A set flag stays set after its cause goes away.
- R7: A read of a flag byte returns its contents on `rd_data_o` one cycle later and clears that byte. Other flag bytes are untouched.
- R8: If a flag's cause is present in the cycle its byte is read, the flag is set again at once, so a later read returns it again.
- R9: Each flag byte has a mask byte at its address plus 0x60, written through the write port and readable. A mask bit of 1 keeps its flag from driving the interrupt, but the flag still latches and reads back.
- R10: `irq_n_o` is 0 exactly when some flag is set and its mask bit is 0. It follows in the same cycle as the flag and mask registers.
- R11: Status byte 2 bit 1 equals the `irq_n_o` level. Bit 0 is 1 from reset until the first sample strobe, then 0. Reading it clears nothing.
- R12: Asserting `rst_n` low clears every flag and mask and sets the not-ready bit again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset, also the module reset input |
| mon_valid_i | input | 1 | Sample strobe: monitor readings are valid this cycle |
| mon_i | input | NQ*VAL_W | Readings; index 0 temperature, 1 supply, 2+t*4+c for type t (0 rx power, 1 tx bias, 2 tx power) and channel c |
| thr_i | input | NQ*4*VAL_W | Limits per reading; [3] upper alarm, [2] lower alarm, [1] upper warning, [0] lower warning |
| los_i | input | 4 | Per-channel loss-of-signal level |
| txflt_i | input | 4 | Per-channel transmit fault level |
| rd_en_i | input | 1 | Host read strobe |
| rd_addr_i | input | 7 | Host read byte address |
| rd_data_o | output | 8 | Read data, valid the cycle after the strobe |
| wr_en_i | input | 1 | Host write strobe (mask bytes only) |
| wr_addr_i | input | 7 | Host write byte address |
| wr_data_i | input | 8 | Host write data |
| irq_n_o | output | 1 | Active-low interrupt |

## Verification
A flag register that fails to hold, or that clears the wrong byte, shows up on the first later read of the affected address. It appears on `rd_data_o` one cycle after the strobe. A wrong mask or pending state shows up on `irq_n_o` at the same clock edge where the flag or mask register changes. A stuck not-ready bit is visible in status byte 2 right after the first sample strobe.

// File: rtl/afl_pkg.sv
// Shared constants, the flag-byte address map and the nibble flag type.
// Assumes four channels, so each per-channel quantity fills two flag bytes.
package afl_pkg;
    localparam int NUM_CH    = 4;
    localparam int CH_BYTES  = NUM_CH / 2;
    localparam int NUM_MODQ  = 2;
    localparam int NUM_CHQ   = 3;
    localparam int NQ        = NUM_MODQ + NUM_CHQ * NUM_CH;
    localparam int NFB       = 2 + NUM_MODQ + NUM_CHQ * CH_BYTES;
    localparam int ADDR_W    = 7;
    localparam logic [ADDR_W-1:0] STATUS_ADDR = 7'd2;
    localparam logic [ADDR_W-1:0] MASK_OFS    = 7'h60;

    // Four limit results of one reading, ordered as they sit in a nibble.
    typedef struct packed {
        logic hi_alm;
        logic lo_alm;
        logic hi_wrn;
        logic lo_wrn;
    } lim_flags_t;

    // Host address of flag byte k: event bytes, module bytes, then channel bytes.
    function automatic logic [ADDR_W-1:0] flag_addr(input int k);
        if (k < 2)
            return ADDR_W'(3 + k);
        else if (k < 4)
            return ADDR_W'(6 + k - 2);
        else
            return ADDR_W'(9 + k - 4);
    endfunction
endpackage

// File: rtl/afl_limit_cmp.sv
// Compares one reading against its four limits with strict inequalities.
// Assumes readings and limits share the same unsigned units.
module afl_limit_cmp
    import afl_pkg::*;
#(
    parameter int VAL_W = 16
) (
    input  logic [VAL_W-1:0]        val_i,
    input  logic [3:0][VAL_W-1:0]   thr_i,
    output lim_flags_t              flg_o
);
    // Four parallel magnitude compares.
    always_comb begin
        flg_o.hi_alm = val_i > thr_i[3];
        flg_o.lo_alm = val_i < thr_i[2];
        flg_o.hi_wrn = val_i > thr_i[1];
        flg_o.lo_wrn = val_i < thr_i[0];
    end
endmodule

// File: rtl/afl_sticky_byte.sv
// One byte of sticky flags plus its mask byte.
// A set request outranks a read-clear in the same cycle, so no event is lost.
// The pending output flags any latched bit that the mask leaves open.
module afl_sticky_byte #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] set_i,
    input  logic              clr_i,
    input  logic              mask_we_i,
    input  logic [BYTE_W-1:0] mask_d_i,
    output logic [BYTE_W-1:0] flags_o,
    output logic [BYTE_W-1:0] mask_o,
    output logic              pend_o
);
    logic [BYTE_W-1:0] flags_q;
    logic [BYTE_W-1:0] mask_q;

    // Latch new events; a read clears whatever is not being set again.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flags_q <= '0;
        else
            flags_q <= (flags_q & ~{BYTE_W{clr_i}}) | set_i;
    end

    // Host-written interrupt mask.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= '0;
        else if (mask_we_i)
            mask_q <= mask_d_i;
    end

    // Unmasked latched flag present.
    assign pend_o  = |(flags_q & ~mask_q);
    assign flags_o = flags_q;
    assign mask_o  = mask_q;

    // R6
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

    // R7
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && (set_i == '0)) |=> (flags_q == '0));

    // R9
    mask_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_we_i |=> $stable(mask_q));
endmodule

// File: rtl/afl_irq_status.sv
// Merges per-byte pending bits into the active-low interrupt and tracks
// the not-ready state that ends with the first sample strobe.
module afl_irq_status #(
    parameter int N_SRC = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] pend_i,
    input  logic             mon_valid_i,
    output logic             irq_n_o,
    output logic             not_ready_o
);
    logic not_ready_q;

    // Not-ready holds until the first valid sample.
    always_ff @(posedge clk) begin
        if (!rst_n)
            not_ready_q <= 1'b1;
        else if (mon_valid_i)
            not_ready_q <= 1'b0;
    end

    // Interrupt low while any byte has an open flag.
    assign irq_n_o     = ~|pend_i;
    assign not_ready_o = not_ready_q;

    // R11
    ready_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !not_ready_q |=> !not_ready_q);
endmodule

// File: rtl/alarm_flag_bank.sv
// Top level: limit compares for all readings, the sticky flag bytes,
// mask bytes, status byte and the host byte read/write port.
// Assumes the host write port targets only mask addresses (flag address + 0x60).
module alarm_flag_bank
    import afl_pkg::*;
#(
    parameter int VAL_W = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          mon_valid_i,
    input  logic [NQ-1:0][VAL_W-1:0]      mon_i,
    input  logic [NQ-1:0][3:0][VAL_W-1:0] thr_i,
    input  logic [NUM_CH-1:0]             los_i,
    input  logic [NUM_CH-1:0]             txflt_i,
    input  logic                          rd_en_i,
    input  logic [ADDR_W-1:0]             rd_addr_i,
    output logic [7:0]                    rd_data_o,
    input  logic                          wr_en_i,
    input  logic [ADDR_W-1:0]             wr_addr_i,
    input  logic [7:0]                    wr_data_i,
    output logic                          irq_n_o
);
    lim_flags_t   lim   [NQ];
    logic [7:0]   set_v [NFB];
    logic [7:0]   flags [NFB];
    logic [7:0]   masks [NFB];
    logic [NFB-1:0] clr_v;
    logic [NFB-1:0] mwe_v;
    logic [NFB-1:0] pend_v;
    logic         not_ready;
    logic         irq_n;
    logic [7:0]   rd_mux;
    logic [7:0]   rd_data_q;

    // One comparator group per reading.
    for (genvar q = 0; q < NQ; q++) begin : g_cmp
        afl_limit_cmp #(.VAL_W(VAL_W)) u_cmp (
            .val_i (mon_i[q]),
            .thr_i (thr_i[q]),
            .flg_o (lim[q])
        );
    end

    // Route events and limit results into their flag-byte positions.
    always_comb begin
        for (int k = 0; k < NFB; k++) set_v[k] = '0;
        set_v[0][NUM_CH-1:0] = los_i;
        set_v[1][NUM_CH-1:0] = txflt_i;
        if (mon_valid_i) begin
            set_v[2][7:4] = lim[0];
            set_v[3][7:4] = lim[1];
            for (int t = 0; t < NUM_CHQ; t++) begin
                for (int c = 0; c < NUM_CH; c++) begin
                    if (c % 2 == 0)
                        set_v[4 + t*CH_BYTES + c/2][7:4] = lim[NUM_MODQ + t*NUM_CH + c];
                    else
                        set_v[4 + t*CH_BYTES + c/2][3:0] = lim[NUM_MODQ + t*NUM_CH + c];
                end
            end
        end
    end

    // Decode read-clear and mask-write strobes per flag byte.
    always_comb begin
        for (int k = 0; k < NFB; k++) begin
            clr_v[k] = rd_en_i && (rd_addr_i == flag_addr(k));
            mwe_v[k] = wr_en_i && (wr_addr_i == flag_addr(k) + MASK_OFS);
        end
    end

    for (genvar k = 0; k < NFB; k++) begin : g_byte
        afl_sticky_byte #(.BYTE_W(8)) u_byte (
            .clk       (clk),
            .rst_n     (rst_n),
            .set_i     (set_v[k]),
            .clr_i     (clr_v[k]),
            .mask_we_i (mwe_v[k]),
            .mask_d_i  (wr_data_i),
            .flags_o   (flags[k]),
            .mask_o    (masks[k]),
            .pend_o    (pend_v[k])
        );
    end

    afl_irq_status #(.N_SRC(NFB)) u_irq (
        .clk         (clk),
        .rst_n       (rst_n),
        .pend_i      (pend_v),
        .mon_valid_i (mon_valid_i),
        .irq_n_o     (irq_n),
        .not_ready_o (not_ready)
    );

    // Select the addressed byte for the host.
    always_comb begin
        rd_mux = '0;
        if (rd_addr_i == STATUS_ADDR)
            rd_mux = {6'b0, irq_n, not_ready};
        for (int k = 0; k < NFB; k++) begin
            if (rd_addr_i == flag_addr(k))
                rd_mux = flags[k];
            if (rd_addr_i == flag_addr(k) + MASK_OFS)
                rd_mux = masks[k];
        end
    end

    // Capture read data before the clear lands.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_data_q <= '0;
        else if (rd_en_i)
            rd_data_q <= rd_mux;
    end

    assign rd_data_o = rd_data_q;
    assign irq_n_o   = irq_n;

    // R10
    irq_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(irq_n_o) && $past(rst_n)) |-> ($past(rd_en_i) || $past(wr_en_i)));

    // R10
    irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_n_o) |-> ($past(mon_valid_i) || $past(|los_i) ||
                            $past(|txflt_i) || $past(wr_en_i)));
endmodule

// File: tb/alarm_flag_bank_test.sv
module alarm_flag_bank_test;
    import afl_pkg::*;
    localparam int VW = 16;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic                       rst_n;
    logic                       mon_valid;
    logic [NQ-1:0][VW-1:0]      mon;
    logic [NQ-1:0][3:0][VW-1:0] thr;
    logic [NUM_CH-1:0]          los, flt;
    logic                       rd_en;
    logic [6:0]                 rd_addr;
    logic [7:0]                 rd_data;
    logic                       wr_en;
    logic [6:0]                 wr_addr;
    logic [7:0]                 wr_data;
    logic                       irq_n;

    alarm_flag_bank #(.VAL_W(VW)) uut (
        .clk(clk), .rst_n(rst_n), .mon_valid_i(mon_valid), .mon_i(mon),
        .thr_i(thr), .los_i(los), .txflt_i(flt), .rd_en_i(rd_en),
        .rd_addr_i(rd_addr), .rd_data_o(rd_data), .wr_en_i(wr_en),
        .wr_addr_i(wr_addr), .wr_data_i(wr_data), .irq_n_o(irq_n)
    );

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } exp_t;

    exp_t sbq[$];
    int   checks = 0;
    int   fails  = 0;
    logic rd_pend = 1'b0;
    bit   done = 0;

    // Monitor: a read issued before the last edge has its data ready now.
    always @(posedge clk) rd_pend <= rd_en;
    always @(negedge clk) begin
        if (rd_pend && sbq.size() > 0) begin
            exp_t e;
            e = sbq.pop_front();
            checks++;
            if (rd_data !== e.exp) begin
                fails++;
                $display("FAIL %s: rd_data=%02h expected %02h", e.tag, rd_data, e.exp);
            end
        end
    end

    task automatic host_read(input logic [6:0] a, input logic [7:0] e, input string tag);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        sbq.push_back('{e, tag});
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic host_write(input logic [6:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_valid();
        @(negedge clk);
        mon_valid = 1'b1;
        @(negedge clk);
        mon_valid = 1'b0;
    endtask

    task automatic check_irq(input logic e, input string tag);
        @(negedge clk);
        checks++;
        if (irq_n !== e) begin
            fails++;
            $display("FAIL %s: irq_n=%0b expected %0b", tag, irq_n, e);
        end
    endtask

    task automatic nominal();
        for (int q = 0; q < NQ; q++) mon[q] = 16'd500;
    endtask

    initial begin
        rst_n = 1'b0; mon_valid = 1'b0; los = '0; flt = '0;
        rd_en = 1'b0; rd_addr = '0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        for (int q = 0; q < NQ; q++) begin
            thr[q][3] = 16'd1000; thr[q][2] = 16'd100;
            thr[q][1] = 16'd800;  thr[q][0] = 16'd200;
        end
        nominal();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check_irq(1'b1, "R1 irq after reset");
        host_read(7'd2, 8'h03, "R1 R11 status after reset");
        host_read(7'd6, 8'h00, "R1 temp byte after reset");
        host_read(7'h66, 8'h00, "R1 mask after reset");

        // R11 not-ready ends with first sample
        pulse_valid();
        host_read(7'd2, 8'h02, "R11 status after first sample");

        // R2 R6 upper alarm and warning, cause removed before the read
        mon[0] = 16'd1001;
        pulse_valid();
        mon[0] = 16'd500;
        check_irq(1'b0, "R10 irq on open flag");
        host_read(7'd2, 8'h00, "R11 status mirrors low irq");
        host_read(7'd6, 8'hA0, "R2 R6 temp above both upper limits");
        host_read(7'd6, 8'h00, "R7 temp byte cleared by read");
        check_irq(1'b1, "R10 irq released after clear");

        // R2 equality boundaries
        mon[0] = 16'd1000; pulse_valid();
        mon[0] = 16'd800;  pulse_valid();
        mon[0] = 16'd500;
        host_read(7'd6, 8'h20, "R2 equal to alarm limit sets warning only");

        // R3 lower limits on the supply byte
        mon[1] = 16'd100; pulse_valid(); mon[1] = 16'd500;
        host_read(7'd7, 8'h10, "R3 equal to lower alarm sets lower warning only");
        mon[1] = 16'd99; pulse_valid(); mon[1] = 16'd500;
        host_read(7'd7, 8'h50, "R3 below both lower limits");

        // R4 placement across channel bytes
        mon[3] = 16'd2000; mon[8] = 16'd50; mon[13] = 16'd150;
        pulse_valid();
        nominal();
        host_read(7'd9,  8'h0A, "R4 rx power ch2 low nibble");
        host_read(7'd10, 8'h00, "R4 rx power ch3 ch4 quiet");
        host_read(7'd11, 8'h00, "R4 bias ch1 ch2 quiet");
        host_read(7'd12, 8'h50, "R4 bias ch3 high nibble");
        host_read(7'd13, 8'h00, "R4 tx power ch1 ch2 quiet");
        host_read(7'd14, 8'h01, "R4 tx power ch4 low nibble");

        // R4 no compare without a sample strobe
        mon[0] = 16'd2000;
        repeat (3) @(negedge clk);
        host_read(7'd6, 8'h00, "R4 no flag without strobe");
        mon[0] = 16'd500;

        // R5 R7 event bytes, one-cycle pulses
        @(negedge clk); los = 4'b0100; flt = 4'b1001;
        @(negedge clk); los = '0; flt = '0;
        host_read(7'd3, 8'h04, "R5 los ch3");
        host_read(7'd3, 8'h00, "R7 los byte cleared");
        host_read(7'd4, 8'h09, "R5 R7 fault byte untouched by other read");
        host_read(7'd4, 8'h00, "R7 fault byte cleared");

        // R8 cause present while read
        @(negedge clk); los = 4'b0001;
        host_read(7'd3, 8'h01, "R8 first read with los held");
        host_read(7'd3, 8'h01, "R8 re-set while los held");
        los = '0;
        host_read(7'd3, 8'h01, "R8 set at last held read");
        host_read(7'd3, 8'h00, "R8 clear once cause gone");

        // R9 mask gates interrupt but not latching
        host_write(7'h66, 8'hF0);
        host_read(7'h66, 8'hF0, "R9 mask readback");
        mon[0] = 16'd1001; pulse_valid(); mon[0] = 16'd500;
        check_irq(1'b1, "R9 masked flag leaves irq high");
        host_read(7'd6, 8'hA0, "R9 masked flag still latched");
        mon[0] = 16'd1001; pulse_valid(); mon[0] = 16'd500;
        host_write(7'h66, 8'h00);
        check_irq(1'b0, "R10 unmasking exposes flag");

        // R12 reset clears flags and masks
        host_write(7'h67, 8'hFF);
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        check_irq(1'b1, "R12 irq after reset");
        host_read(7'd6, 8'h00, "R12 flags cleared by reset");
        host_read(7'h67, 8'h00, "R12 mask cleared by reset");
        host_read(7'd2, 8'h03, "R12 not-ready set again");

        repeat (2) @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R1 watchdog: done=0 expected 1");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule